// File: doc/BRIEF.md
# Rotating Register Base Renamer

This block turns the register number named by an instruction into the number of the physical register that holds the value. It serves three register classes: general, floating-point and predicate. Each class keeps its own rotating base. Registers below a class's rotating region pass through unchanged. A register inside the region is shifted by that class's base, and the shift wraps around within the region.

The loop-branch logic drives two strobes. A decrement strobe moves all three bases down by one in the same cycle, so a value written through virtual register `n` is read one loop iteration later through virtual register `n+1`. A clear strobe returns all three bases to zero.

The translation is combinational from the current bases. The general class's rotating size is supplied by the surrounding frame logic as a register count.

Top module: `rrb_renamer`

## Requirements
- R1: While reset is held, all three bases are zero, so every virtual number maps to itself.
- R2: Static registers pass through unchanged. These are virtual numbers below 32 for the general and floating-point classes, and below 16 for the predicate class.
- R3: Floating-point virtual numbers 32 to 127 map to 32 + ((v − 32 + base) mod 96).
- R4: Predicate virtual numbers 16 to 63 map to 16 + ((v − 16 + base) mod 48).
- R5: For a valid general rotating size S (S = 8·m, S ≤ 96), virtual numbers 32 to 32+S−1 map to 32 + ((v − 32 + base) mod S). General numbers at or above 32+S pass through unchanged.
- R6: Each cycle with `rrb_dec` high and `rrb_clr` low lowers every base by one, modulo its region size. The new mapping is visible after that clock edge.
- R7: `rrb_clr` sets all three bases to zero at the next edge and takes priority over `rrb_dec`.
- R8: A general size that is not a multiple of 8, or that exceeds 96, raises `gr_size_bad` and disables general rotation. A size of zero also disables general rotation, but does not raise `gr_size_bad`. While general rotation is disabled, the general base stays at zero.
- R9: Class code 3 is reserved and passes every number through unchanged. The class codes are 0 general, 1 floating-point, 2 predicate.
- R10: With neither strobe asserted, the bases hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cls_sel | input | 2 | Register class: 0 general, 1 floating-point, 2 predicate, 3 none |
| vreg | input | 7 | Virtual register number |
| gr_rot_size | input | 7 | General rotating region size, in registers |
| rrb_dec | input | 1 | Decrement all bases (loop branch taken) |
| rrb_clr | input | 1 | Reset all bases to zero |
| preg | output | 7 | Physical register number |
| gr_size_bad | output | 1 | General rotating size is not accepted |

## Verification
The bench builds the block with its default file sizes: 128 general, 128 floating-point and 64 predicate registers, with the regions starting at 32, 32 and 16. This makes every virtual number of every class reachable.

After each decrement, the bench sweeps every virtual number of every class. It takes the floating-point base past a full 96-step wrap and the predicate base past two 48-step wraps. It also walks every one of the 128 general size codes, each followed by a clear and a run of decrements. This covers every legal region size, the disabled size and every rejected size.

// File: rtl/rrb_renamer.sv
module rrb_renamer #(
  parameter int GR_REGS  = 128,
  parameter int FR_REGS  = 128,
  parameter int PR_REGS  = 64,
  parameter int GR_START = 32,
  parameter int FR_START = 32,
  parameter int PR_START = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [1:0]           cls_sel,
  input  logic [$clog2((GR_REGS > FR_REGS ? (GR_REGS > PR_REGS ? GR_REGS : PR_REGS)
                       : (FR_REGS > PR_REGS ? FR_REGS : PR_REGS)))-1:0] vreg,
  input  logic [$clog2((GR_REGS > FR_REGS ? (GR_REGS > PR_REGS ? GR_REGS : PR_REGS)
                       : (FR_REGS > PR_REGS ? FR_REGS : PR_REGS)))-1:0] gr_rot_size,
  input  logic                 rrb_dec,
  input  logic                 rrb_clr,
  output logic [$clog2((GR_REGS > FR_REGS ? (GR_REGS > PR_REGS ? GR_REGS : PR_REGS)
                       : (FR_REGS > PR_REGS ? FR_REGS : PR_REGS)))-1:0] preg,
  output logic                 gr_size_bad
);
  localparam int MAXR = (GR_REGS > FR_REGS ? (GR_REGS > PR_REGS ? GR_REGS : PR_REGS)
                        : (FR_REGS > PR_REGS ? FR_REGS : PR_REGS));
  localparam int RW = $clog2(MAXR);
  localparam logic [RW:0] GS   = (RW+1)'(GR_START);
  localparam logic [RW:0] FS   = (RW+1)'(FR_START);
  localparam logic [RW:0] PS   = (RW+1)'(PR_START);
  localparam logic [RW:0] GMAX = (RW+1)'(GR_REGS - GR_START);
  localparam logic [RW:0] FSZ  = (RW+1)'(FR_REGS - FR_START);
  localparam logic [RW:0] PSZ  = (RW+1)'(PR_REGS - PR_START);

  localparam logic [1:0] CLS_GR = 2'd0;
  localparam logic [1:0] CLS_FR = 2'd1;
  localparam logic [1:0] CLS_PR = 2'd2;

  logic [RW-1:0] rrb_gr, rrb_fr, rrb_pr;
  logic [RW:0]   gr_sz;
  logic          gr_ok;

  assign gr_ok       = (gr_rot_size[2:0] == 3'b000) && ({1'b0, gr_rot_size} <= GMAX);
  assign gr_size_bad = !gr_ok;
  assign gr_sz       = gr_ok ? {1'b0, gr_rot_size} : '0;

  function automatic logic [RW-1:0] rot_map(input logic [RW-1:0] v, input logic [RW:0] start,
                                            input logic [RW:0] size, input logic [RW-1:0] base);
    logic [RW:0] off, sum;
    if (size != '0 && {1'b0, v} >= start && {1'b0, v} < start + size) begin
      off = {1'b0, v} - start;
      sum = off + {1'b0, base};
      if (sum >= size) sum = sum - size;
      rot_map = RW'(sum + start);
    end else begin
      rot_map = v;
    end
  endfunction

  always_comb begin
    case (cls_sel)
      CLS_GR:  preg = rot_map(vreg, GS, gr_sz, rrb_gr);
      CLS_FR:  preg = rot_map(vreg, FS, FSZ, rrb_fr);
      CLS_PR:  preg = rot_map(vreg, PS, PSZ, rrb_pr);
      default: preg = vreg;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n || rrb_clr) begin
      rrb_gr <= '0;
      rrb_fr <= '0;
      rrb_pr <= '0;
    end else if (rrb_dec) begin
      if (gr_sz == '0)
        rrb_gr <= '0;
      else if (rrb_gr == '0 || {1'b0, rrb_gr} >= gr_sz)
        rrb_gr <= RW'(gr_sz - 1'b1);
      else
        rrb_gr <= rrb_gr - 1'b1;
      rrb_fr <= (rrb_fr == '0) ? RW'(FSZ - 1'b1) : rrb_fr - 1'b1;
      rrb_pr <= (rrb_pr == '0) ? RW'(PSZ - 1'b1) : rrb_pr - 1'b1;
    end
  end

  p_static_fr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cls_sel == CLS_FR && {1'b0, vreg} < FS) |-> preg == vreg);
  p_fr_in_region_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cls_sel == CLS_FR && {1'b0, vreg} >= FS) |-> {1'b0, preg} >= FS);
  p_pr_in_region_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cls_sel == CLS_PR && {1'b0, vreg} >= PS && {1'b0, vreg} < PS + PSZ)
      |-> ({1'b0, preg} >= PS && {1'b0, preg} < PS + PSZ));
  p_base_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, rrb_fr} < FSZ) && ({1'b0, rrb_pr} < PSZ));
  p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rrb_clr |=> (rrb_gr == '0 && rrb_fr == '0 && rrb_pr == '0));
  p_bad_size_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (gr_size_bad && cls_sel == CLS_GR) |-> preg == vreg);
  p_reserved_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cls_sel == 2'd3) |-> preg == vreg);
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!rrb_dec && !rrb_clr) |=> ($stable(rrb_gr) && $stable(rrb_fr) && $stable(rrb_pr)));
endmodule

// File: tb/tb_rrb_renamer.sv
module tb_rrb_renamer;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] cls_sel = 2'd0;
  logic [6:0] vreg = '0;
  logic [6:0] gr_rot_size = 7'd96;
  logic       rrb_dec = 1'b0;
  logic       rrb_clr = 1'b0;
  logic [6:0] preg;
  logic       gr_size_bad;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  rrb_renamer dut (
    .clk(clk), .rst_n(rst_n), .cls_sel(cls_sel), .vreg(vreg),
    .gr_rot_size(gr_rot_size), .rrb_dec(rrb_dec), .rrb_clr(rrb_clr),
    .preg(preg), .gr_size_bad(gr_size_bad)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int model(input int v, input int start, input int size, input int k);
    int off;
    if (size == 0 || v < start || v >= start + size) return v;
    off = v - start;
    return start + ((((off - k) % size) + size) % size);
  endfunction

  function automatic bit size_bad(input int s);
    return (s % 8 != 0) || (s > 96);
  endfunction

  task automatic probe(input int c, input int v, output int r);
    cls_sel = 2'(c);
    vreg = 7'(v);
    #1;
    r = int'(preg);
  endtask

  task automatic sweep(input int k, input int grs, input bit gr_only);
    int r;
    int eff;
    eff = size_bad(grs) ? 0 : grs;
    for (int v = 0; v < 128; v++) begin
      probe(0, v, r);
      if (size_bad(grs)) chk("R8", r, v);
      else if (v < 32) chk("R2", r, v);
      else chk("R5", r, model(v, 32, eff, k));
      if (!gr_only) begin
        probe(1, v, r);
        chk(v < 32 ? "R2" : "R3", r, model(v, 32, 96, k));
        if (v < 64) begin
          probe(2, v, r);
          chk(v < 16 ? "R2" : "R4", r, model(v, 16, 48, k));
        end
        probe(3, v, r);
        chk("R9", r, v);
      end
    end
  endtask

  task automatic dec_once();
    @(negedge clk) rrb_dec = 1'b1;
    @(negedge clk) rrb_dec = 1'b0;
  endtask

  initial begin
    int r;
    int k;
    repeat (3) @(negedge clk);
    probe(1, 40, r);
    chk("R1", r, 40);
    probe(2, 20, r);
    chk("R1", r, 20);
    rst_n = 1'b1;
    @(negedge clk);
    k = 0;
    sweep(k, 96, 0);
    chk("R8", int'(gr_size_bad), 0);

    for (int i = 0; i < 100; i++) begin
      dec_once();
      k++;
      probe(1, 32, r);
      chk("R6", r, model(32, 32, 96, k));
      sweep(k, 96, 0);
    end

    repeat (5) @(negedge clk);
    probe(1, 32, r);
    chk("R10", r, model(32, 32, 96, k));
    probe(2, 17, r);
    chk("R10", r, model(17, 16, 48, k));

    @(negedge clk) begin rrb_clr = 1'b1; rrb_dec = 1'b1; end
    @(negedge clk) begin rrb_clr = 1'b0; rrb_dec = 1'b0; end
    k = 0;
    probe(1, 32, r);
    chk("R7", r, 32);
    probe(2, 63, r);
    chk("R7", r, 63);
    probe(0, 100, r);
    chk("R7", r, 100);

    for (int s = 0; s < 128; s++) begin
      @(negedge clk) begin gr_rot_size = 7'(s); rrb_clr = 1'b1; end
      @(negedge clk) rrb_clr = 1'b0;
      #1;
      chk("R8", int'(gr_size_bad), int'(size_bad(s)));
      for (int j = 0; j < 10; j++) begin
        dec_once();
        sweep(j + 1, s, 1);
      end
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule